// File: doc/BRIEF.md
# Truncated Symbol Gap Filler

This unit sits on the decompression path of a compressed-memory controller, right after the symbol decoder. For each 128-byte block it takes a small header and the stream of 16-bit symbols that survived decoding. It returns all 64 symbols of the block in order on a valid/ready output stream, with a last flag on the final symbol. A block may have been compressed lossily: a contiguous run of up to 16 symbols was dropped before storage. The header gives where that run starts and how long it is. The unit writes a substitute value into each dropped position and takes no input for those positions.

Two fill policies are available, selected by `fill_pred` when the header is accepted. Zero fill writes 0 into every dropped position. Prediction fill copies the first surviving symbol of the block into the gap. When the gap starts at position 0, that symbol is the one at position `len`. The unit then takes it from the input before it emits anything (state PRIME), keeps it in a register, and releases it again at its own position. An uncompressed block has no meaningful header and passes through unchanged, and so does a lossless block.

The controller has three states:
- IDLE accepts a header. It moves to PRIME when the block is lossy, uses prediction fill and has its gap starting at 0, and to STREAM in every other case.
- PRIME takes one input symbol and then moves to STREAM.
- STREAM emits positions 0 to 63 and returns to IDLE after position 63 is accepted.

Top module: `symbol_gap_filler`

## Requirements
- R1: A header is accepted (`hdr_valid` and `hdr_ready` both high) only while no block is in progress. After acceptance `hdr_ready` stays low until exactly 64 output symbols have been accepted, and no output is given without an accepted header.
- R2: With `hdr_raw`=1 (uncompressed; `hdr_lossy` is then ignored) or `hdr_lossy`=0 (lossless), the 64 output symbols equal the 64 input symbols in order, and exactly 64 inputs are consumed.
- R3: With `hdr_raw`=0 and `hdr_lossy`=1, `hdr_cnt_m1` holds the gap length minus one (1 to 16). The gap covers positions `hdr_start` through `hdr_start+hdr_cnt_m1`, clipped at 63. Non-gap positions carry the input symbols in order, exactly 64 minus the gap size inputs are consumed, and `in_ready` stays low while a gap position is presented.
- R4: With `fill_pred`=0 every gap position outputs 0.
- R5: With `fill_pred`=1 and `hdr_start`>0 every gap position outputs the symbol at position 0.
- R6: With `fill_pred`=1 and `hdr_start`=0 every gap position outputs the symbol at position `hdr_cnt_m1+1`. That symbol is the first input taken, and `out_valid` stays low until it has been taken.
- R7: `out_last` is high on the 64th output symbol of a block and on no other accepted output.
- R8: While `out_valid` is high and `out_ready` is low, no input is consumed, the position does not advance, and `out_data` is held.
- R9: The fill policy is sampled when the header is accepted. Changing `fill_pred` during a block has no effect on that block.
- R10: After reset `hdr_ready`=1, `out_valid`=0 and `in_ready`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fill_pred | input | 1 | Fill policy: 0 zero, 1 copy of first surviving symbol |
| hdr_valid | input | 1 | Header present |
| hdr_ready | output | 1 | Header can be accepted (idle) |
| hdr_raw | input | 1 | 1 = uncompressed block, header fields ignored |
| hdr_lossy | input | 1 | 1 = lossy block, 0 = lossless |
| hdr_start | input | 6 | Position of the first dropped symbol |
| hdr_cnt_m1 | input | 4 | Number of dropped symbols minus one |
| in_valid | input | 1 | Decoded symbol present |
| in_ready | output | 1 | Decoded symbol taken |
| in_data | input | 16 | Decoded symbol |
| out_valid | output | 1 | Output symbol present |
| out_ready | input | 1 | Downstream accepts output symbol |
| out_data | output | 16 | Reconstructed symbol |
| out_last | output | 1 | Marks position 63 |

## Verification
Blocks are sent as raw, lossless and lossy, with raw also set together with the lossy flag. This shows whether the header bypass is honoured and whether the lossy flag really is ignored. Lossy blocks place the gap in the middle, at position 0 with lengths 1 and 16, and at the tail with and without clipping at 63. Each is run under both fill policies, which separates the zero, position-0 and position-len predictor paths, the PRIME detour, and the gap-end arithmetic. Random stalls on both sides, and a run with no stalls, test the hold behaviour. Toggling the policy input in the middle of a block shows whether it is latched at header acceptance.

// File: rtl/slr_pkg.sv
package slr_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_PRIME  = 2'd1,
        ST_STREAM = 2'd2
    } slr_state_e;
endpackage

// File: rtl/slr_hdr_reg.sv
module slr_hdr_reg #(
    parameter int IDX_W = 6,
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             hdr_raw,
    input  logic             hdr_lossy,
    input  logic [IDX_W-1:0] hdr_start,
    input  logic [CNT_W-1:0] hdr_cnt_m1,
    input  logic             fill_pred,
    output logic             lossy_q,
    output logic             pred_q,
    output logic [IDX_W-1:0] start_q,
    output logic [IDX_W:0]   gap_end_q
);
    localparam int EW = IDX_W + 1;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lossy_q   <= 1'b0;
            pred_q    <= 1'b0;
            start_q   <= '0;
            gap_end_q <= '0;
        end else if (load) begin
            lossy_q   <= !hdr_raw && hdr_lossy;
            pred_q    <= fill_pred;
            start_q   <= hdr_start;
            gap_end_q <= EW'(hdr_start) + EW'(hdr_cnt_m1) + EW'(1);
        end
    end

    // R9: block configuration only changes on a header load
    p_cfg_held_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> ($stable(pred_q) && $stable(lossy_q) && $stable(gap_end_q)));
endmodule

// File: rtl/slr_gap_window.sv
module slr_gap_window #(
    parameter int IDX_W = 6
) (
    input  logic             lossy,
    input  logic [IDX_W-1:0] start,
    input  logic [IDX_W:0]   gap_end,
    input  logic [IDX_W-1:0] idx,
    output logic             in_gap
);
    always_comb begin
        in_gap = lossy && (idx >= start) && ({1'b0, idx} < gap_end);
    end
endmodule

// File: rtl/slr_fill_hold.sv
module slr_fill_hold #(
    parameter int SYM_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             capture,
    input  logic [SYM_W-1:0] cap_data,
    input  logic             set_hold,
    input  logic             take_hold,
    input  logic             use_pred,
    output logic [SYM_W-1:0] fill_val,
    output logic             hold_vld,
    output logic [SYM_W-1:0] hold_val
);
    logic [SYM_W-1:0] pred_r;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pred_r   <= '0;
            hold_vld <= 1'b0;
        end else begin
            if (capture) pred_r <= cap_data;
            if (set_hold)       hold_vld <= 1'b1;
            else if (take_hold) hold_vld <= 1'b0;
        end
    end

    always_comb begin
        fill_val = use_pred ? pred_r : '0;
        hold_val = pred_r;
    end

    // R6: the held predictor is captured once and released before the next capture
    p_single_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        set_hold |-> !hold_vld);
    // R6: the held symbol is released exactly once
    p_hold_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
        take_hold |=> !hold_vld);
endmodule

// File: rtl/symbol_gap_filler.sv
module symbol_gap_filler
    import slr_pkg::*;
#(
    parameter int SYM_W   = 16,
    parameter int NUM_SYM = 64,
    parameter int CNT_W   = 4,
    localparam int IDX_W  = $clog2(NUM_SYM)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fill_pred,
    input  logic             hdr_valid,
    output logic             hdr_ready,
    input  logic             hdr_raw,
    input  logic             hdr_lossy,
    input  logic [IDX_W-1:0] hdr_start,
    input  logic [CNT_W-1:0] hdr_cnt_m1,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [SYM_W-1:0] in_data,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [SYM_W-1:0] out_data,
    output logic             out_last
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_SYM - 1);

    slr_state_e       state, state_d;
    logic [IDX_W-1:0] idx, idx_d;
    logic             load, need_prime, fire;
    logic             lossy_q, pred_q, in_gap;
    logic [IDX_W-1:0] start_q;
    logic [IDX_W:0]   gap_end_q;
    logic             capture, set_hold, take_hold, hold_vld;
    logic [SYM_W-1:0] fill_val, hold_val;

    assign load       = hdr_valid && (state == ST_IDLE);
    assign need_prime = !hdr_raw && hdr_lossy && fill_pred && (hdr_start == '0);

    slr_hdr_reg #(.IDX_W(IDX_W), .CNT_W(CNT_W)) u_hdr (
        .clk(clk), .rst_n(rst_n), .load(load),
        .hdr_raw(hdr_raw), .hdr_lossy(hdr_lossy),
        .hdr_start(hdr_start), .hdr_cnt_m1(hdr_cnt_m1), .fill_pred(fill_pred),
        .lossy_q(lossy_q), .pred_q(pred_q), .start_q(start_q), .gap_end_q(gap_end_q)
    );

    slr_gap_window #(.IDX_W(IDX_W)) u_win (
        .lossy(lossy_q), .start(start_q), .gap_end(gap_end_q),
        .idx(idx), .in_gap(in_gap)
    );

    slr_fill_hold #(.SYM_W(SYM_W)) u_fill (
        .clk(clk), .rst_n(rst_n), .capture(capture), .cap_data(in_data),
        .set_hold(set_hold), .take_hold(take_hold), .use_pred(pred_q),
        .fill_val(fill_val), .hold_vld(hold_vld), .hold_val(hold_val)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            idx   <= '0;
        end else begin
            state <= state_d;
            idx   <= idx_d;
        end
    end

    // next state
    always_comb begin
        state_d = state;
        idx_d   = idx;
        unique case (state)
            ST_IDLE: begin
                if (hdr_valid) begin
                    state_d = need_prime ? ST_PRIME : ST_STREAM;
                    idx_d   = '0;
                end
            end
            ST_PRIME: begin
                if (in_valid) state_d = ST_STREAM;
            end
            ST_STREAM: begin
                if (fire) begin
                    if (idx == LAST_IDX) begin
                        state_d = ST_IDLE;
                        idx_d   = '0;
                    end else begin
                        idx_d = idx + IDX_W'(1);
                    end
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        hdr_ready = 1'b0;
        in_ready  = 1'b0;
        out_valid = 1'b0;
        out_data  = '0;
        out_last  = 1'b0;
        fire      = 1'b0;
        capture   = 1'b0;
        set_hold  = 1'b0;
        take_hold = 1'b0;
        unique case (state)
            ST_IDLE: hdr_ready = 1'b1;
            ST_PRIME: begin
                in_ready = 1'b1;
                capture  = in_valid;
                set_hold = in_valid;
            end
            ST_STREAM: begin
                if (in_gap) begin
                    out_valid = 1'b1;
                    out_data  = fill_val;
                end else if (hold_vld) begin
                    out_valid = 1'b1;
                    out_data  = hold_val;
                end else begin
                    out_valid = in_valid;
                    out_data  = in_data;
                    in_ready  = out_ready;
                end
                out_last  = (idx == LAST_IDX);
                fire      = out_valid && out_ready;
                take_hold = fire && !in_gap && hold_vld;
                capture   = fire && !in_gap && !hold_vld && (idx == '0);
            end
            default: ;
        endcase
    end

    // R1: no second header while a block is in flight
    p_hdr_block_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (hdr_valid && hdr_ready) |=> !hdr_ready);
    // R7: accepting the last symbol ends the block
    p_last_return_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready && out_last) |=> hdr_ready);
    // R3: a gap position never takes input
    p_gap_no_input_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_STREAM && in_gap) |-> !in_ready);
    // R4: zero policy emits zero in the gap
    p_zero_fill_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && in_gap && !pred_q) |-> (out_data == '0));
    // R6: nothing is emitted while the predictor is being fetched
    p_prime_silent_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PRIME) |-> !out_valid);
    // R8: a stalled output takes no input and keeps its position
    p_stall_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_STREAM && out_valid && !out_ready) |-> (!in_ready ##1 $stable(idx)));
endmodule

// File: tb/tb_symbol_gap_filler.sv
module tb_symbol_gap_filler;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fill_pred = 1'b0;
    logic        hdr_valid = 1'b0;
    logic        hdr_ready;
    logic        hdr_raw = 1'b0;
    logic        hdr_lossy = 1'b0;
    logic [5:0]  hdr_start = '0;
    logic [3:0]  hdr_cnt_m1 = '0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [15:0] in_data = '0;
    logic        out_valid;
    logic        out_ready = 1'b0;
    logic [15:0] out_data;
    logic        out_last;

    always #4 clk = ~clk;

    symbol_gap_filler dut (
        .clk(clk), .rst_n(rst_n), .fill_pred(fill_pred),
        .hdr_valid(hdr_valid), .hdr_ready(hdr_ready), .hdr_raw(hdr_raw),
        .hdr_lossy(hdr_lossy), .hdr_start(hdr_start), .hdr_cnt_m1(hdr_cnt_m1),
        .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
        .out_last(out_last)
    );

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [15:0] in_q[$];
    logic [15:0] exp_data[$];
    bit          exp_last[$];
    string       exp_tag[$];
    bit          popped = 0;
    bit          hdr_taken = 0;
    bit          block_active = 0;
    bit          stall_prev = 0;
    logic [15:0] prev_data = '0;
    int          in_cnt = 0;
    bit          run_drv = 0;
    bit          rand_stall = 1;

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // input/ready driver
    initial begin
        forever begin
            @(posedge clk); #1;
            if (run_drv) begin
                if (popped || !in_valid) begin
                    if (in_q.size() > 0 && (!rand_stall || ($urandom % 4) != 0)) begin
                        in_valid = 1'b1;
                        in_data  = in_q[0];
                    end else begin
                        in_valid = 1'b0;
                    end
                end
                popped = 0;
                out_ready = !rand_stall || (($urandom % 3) != 0);
            end
        end
    end

    // monitor: reference comparison on every clock
    initial begin
        forever begin
            @(negedge clk);
            if (run_drv) begin
                if (stall_prev) begin
                    chk(out_valid, "R8", "valid dropped during stall", int'(out_valid), 1);
                    chk(out_data == prev_data, "R8", "data changed during stall",
                        int'(out_data), int'(prev_data));
                end
                if (block_active)
                    chk(!hdr_ready, "R1", "hdr_ready during block", int'(hdr_ready), 0);
                if (out_valid && out_ready) begin
                    if (exp_data.size() == 0) begin
                        chk(1'b0, "R1", "output without header", int'(out_data), 0);
                    end else begin
                        automatic logic [15:0] ed = exp_data.pop_front();
                        automatic bit el = exp_last.pop_front();
                        automatic string et = exp_tag.pop_front();
                        chk(out_data == ed, et, "symbol", int'(out_data), int'(ed));
                        chk(out_last == el, "R7", "last flag", int'(out_last), int'(el));
                        if (el) block_active = 0;
                    end
                end
                stall_prev = out_valid && !out_ready;
                prev_data  = out_data;
                if (in_valid && in_ready) begin
                    void'(in_q.pop_front());
                    popped = 1;
                    in_cnt++;
                end
                if (hdr_valid && hdr_ready) begin
                    hdr_taken    = 1;
                    block_active = 1;
                end
            end
        end
    end

    task automatic run_block(input bit raw, input bit lossy, input bit pred,
                             input int start, input int cnt_m1, input int kind,
                             input bit flip);
        logic [15:0] sym[64];
        int len, gend, gsz;
        logic [15:0] pv;
        bit is_lossy;
        is_lossy = !raw && lossy;
        len  = cnt_m1 + 1;
        gend = (start + len > 64) ? 64 : start + len;
        gsz  = is_lossy ? gend - start : 0;
        for (int i = 0; i < 64; i++) begin
            case (kind)
                0: sym[i] = 16'($urandom) | 16'h0001;
                1: sym[i] = 16'(i * 16'h0101 + 16'h0011);
                default: sym[i] = 16'hFFFF - 16'(i);
            endcase
        end
        pv = (start == 0) ? sym[len] : sym[0];
        in_cnt = 0;
        for (int i = 0; i < 64; i++) begin
            automatic bit g = is_lossy && i >= start && i < gend;
            if (g) begin
                exp_data.push_back(pred ? pv : 16'h0000);
                if (flip)              exp_tag.push_back("R9");
                else if (!pred)        exp_tag.push_back("R4");
                else if (start == 0)   exp_tag.push_back("R6");
                else                   exp_tag.push_back("R5");
            end else begin
                exp_data.push_back(sym[i]);
                in_q.push_back(sym[i]);
                exp_tag.push_back(is_lossy ? "R3" : "R2");
            end
            exp_last.push_back(i == 63);
        end
        @(posedge clk); #1;
        hdr_raw = raw; hdr_lossy = lossy; fill_pred = pred;
        hdr_start = 6'(start); hdr_cnt_m1 = 4'(cnt_m1);
        hdr_valid = 1'b1;
        while (!hdr_taken) @(negedge clk);
        @(posedge clk); #1;
        hdr_valid = 1'b0;
        hdr_taken = 0;
        if (flip) fill_pred = !pred;
        while (exp_data.size() > 0) @(negedge clk);
        repeat (3) @(negedge clk);
        chk(in_cnt == 64 - gsz, is_lossy ? "R3" : "R2", "inputs consumed", in_cnt, 64 - gsz);
        chk(in_q.size() == 0, is_lossy ? "R3" : "R2", "inputs left", in_q.size(), 0);
        chk(hdr_ready, "R1", "idle after block", int'(hdr_ready), 1);
        in_q.delete();
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        chk(hdr_ready == 1'b1, "R10", "reset hdr_ready", int'(hdr_ready), 1);
        chk(out_valid == 1'b0, "R10", "reset out_valid", int'(out_valid), 0);
        chk(in_ready == 1'b0, "R10", "reset in_ready", int'(in_ready), 0);
        rst_n = 1'b1;
        run_drv = 1;
        run_block(1, 0, 0, 0, 0, 0, 0);   // R2 raw
        run_block(1, 1, 1, 7, 9, 1, 0);   // R2 raw, lossy flag ignored
        run_block(0, 0, 1, 3, 3, 0, 0);   // R2 lossless
        run_block(0, 1, 0, 10, 5, 0, 0);  // R4 mid gap zero
        run_block(0, 1, 1, 20, 15, 1, 0); // R5 mid gap predicted
        run_block(0, 1, 1, 0, 15, 0, 0);  // R6 gap at 0, len 16
        run_block(0, 1, 1, 0, 0, 2, 0);   // R6 gap at 0, len 1
        run_block(0, 1, 0, 0, 3, 1, 0);   // R4 gap at 0 zero
        run_block(0, 1, 1, 60, 15, 0, 0); // R3 clipped tail
        run_block(0, 1, 1, 63, 0, 2, 0);  // R3 last symbol only
        run_block(0, 1, 1, 5, 7, 0, 1);   // R9 policy flip after header
        run_block(0, 1, 0, 40, 2, 1, 1);  // R9 policy flip after header
        rand_stall = 0;
        run_block(0, 1, 1, 0, 7, 0, 0);   // R6 without stalls
        run_block(0, 1, 1, 48, 15, 1, 0); // R3 gap ending exactly at 63
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule